// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Buffer

This block is the transmit side of one isochronous IN endpoint in a USB device function. Firmware writes packet bytes into a bank, then pulses a ready strobe to hand the bank over. When the serial engine later reports an IN token for the endpoint, the block plays the bank out one byte per cycle with a valid strobe and a last strobe. After the serial engine acknowledges that the packet left, the block marks the bank complete. Firmware must clear that flag before it can refill the bank. If the current bank has not been handed over when a token arrives, nothing is returned.

The block has two buffering modes. In single mode one bank is used. In ping-pong mode two banks alternate, and each ready strobe moves the firmware's write pointer to the other bank, so firmware can fill one bank while the other waits to be sent. The block also records the end of a bus reset. That event returns all endpoint state to its defaults, but the enable and configuration inputs keep their values. The block raises no further reset indication until firmware clears the recorded flag.

Top module: `iso_in_ep_ctrl`

## Requirements
- R1: An IN token produces no output unless `ep_enable` and `ep_config` are both 1. A ready bank stays ready, and is sent on a later token once both inputs are 1.
- R2: On an accepted token, from the next cycle the bank's bytes appear on `tx_data` in the order written, one per cycle with `tx_valid` = 1, and `tx_last` = 1 on the final byte only. The block then waits for `tx_ack`.
- R3: An IN token while the bank under the read pointer is not ready produces no `tx_valid` and no `tx_last`.
- R4: A `tx_ack` after a packet clears that bank's ready flag and sets its complete flag. `irq` is 1 exactly when `int_en` is 1 and a complete flag or the end-of-reset flag is set.
- R5: Writes to a bank whose ready flag or complete flag is set are ignored. After `clr_done`, a refill starts again at the first byte.
- R6: `fw_ready` and `fw_done` show the flags of the bank under the write pointer. In ping-pong mode (`pingpong` = 1) an accepted `set_ready` moves the write pointer to the other bank. In single mode the pointer stays on bank 0.
- R7: In ping-pong mode the banks are sent strictly in alternation, starting with bank 0. A token aimed at a bank that is not ready gets no data.
- R8: A bank holds up to BANK_DEPTH bytes. Further writes are ignored and set the sticky `wr_ovf`, while exactly BANK_DEPTH writes leave it clear.
- R9: A bank marked ready with no bytes answers a token with one cycle of `tx_last` = 1 and `tx_valid` = 0.
- R10: A `bus_reset_end` pulse while `eor_flag` is 0 sets `eor_flag` and clears every ready and complete flag, both bank pointers, the byte counts and `wr_ovf`.
- R11: While `eor_flag` is 1, further `bus_reset_end` pulses are ignored and leave endpoint state unchanged. `clr_eor` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_enable | input | 1 | Endpoint enabled |
| ep_config | input | 1 | Endpoint configured |
| pingpong | input | 1 | 1 = two alternating banks, 0 = one bank |
| int_en | input | 1 | Interrupt enable |
| wr_valid | input | 1 | Firmware byte write strobe |
| wr_data | input | DATA_W | Firmware byte |
| set_ready | input | 1 | Pulse: hand the write-pointer bank to the sender |
| clr_done | input | 1 | Pulse: clear complete flag of the write-pointer bank |
| fw_ready | output | 1 | Ready flag of the write-pointer bank |
| fw_done | output | 1 | Complete flag of the write-pointer bank |
| wr_ovf | output | 1 | Sticky: a write hit a full bank |
| in_token | input | 1 | Pulse: IN token for this endpoint |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | DATA_W | Outgoing byte |
| tx_last | output | 1 | Final strobe of the packet |
| tx_ack | input | 1 | Pulse: packet has left |
| bus_reset_end | input | 1 | Pulse: end of bus reset seen |
| clr_eor | input | 1 | Pulse: clear end-of-reset flag |
| eor_flag | output | 1 | End-of-reset flag |
| irq | output | 1 | Endpoint interrupt |

## Verification
The hardest state to reach is a ping-pong state in which the two pointers and the flags of the two banks differ. An example is the read pointer back on bank 0 while bank 1 still holds an uncleared complete flag, so that `fw_done` must read 0 and `irq` must still be 1. The stimulus gets there by readying both banks back to back, then sending and acknowledging them in turn while clearing only bank 0's flag. A further token then probes the silent case. A second hard state is a bus-reset pulse arriving while the flag is still set: the bench readies a bank between two such pulses to show that nothing was cleared.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/iso_in_rst_sync.sv
module iso_in_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/iso_in_bank_store.sv
module iso_in_bank_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_clear,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rel_en,
  input  logic              rel_bank,
  input  logic              rd_bank,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf
);
  localparam int NBANK = 2;

  logic [NBANK-1:0][CNT_W-1:0]  cnt_vec;
  logic [NBANK-1:0][DATA_W-1:0] data_vec;
  logic                         ovf_q, ovf_d;
  logic                         wr_full;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              hit, full, store;

    assign hit   = wr_en && (wr_bank == 1'(b));
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign store = hit && !full && !ep_clear;

    always_comb begin
      cnt_d = cnt_q;
      if (ep_clear || (rel_en && rel_bank == 1'(b))) cnt_d = '0;
      else if (store)                                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
      if (store) mem_q[cnt_q[IDX_W-1:0]] <= wr_data;
    end

    assign cnt_vec[b]  = cnt_q;
    assign data_vec[b] = mem_q[rd_idx];

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH)); // R8
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && hit && !ep_clear && !(rel_en && rel_bank == 1'(b))) |=> (cnt_q == CNT_W'(DEPTH))); // R8
  end

  assign wr_full = (cnt_vec[wr_bank] == CNT_W'(DEPTH));

  always_comb begin
    ovf_d = ovf_q;
    if (ep_clear)              ovf_d = 1'b0;
    else if (wr_en && wr_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign rd_cnt  = cnt_vec[rd_bank];
  assign rd_data = data_vec[rd_bank];
  assign ovf     = ovf_q;
endmodule

// File: rtl/iso_in_tx_seq.sv
module iso_in_tx_seq
  import iso_in_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_clear,
  input  logic             start,
  input  logic [CNT_W-1:0] bank_cnt,
  input  logic             ack,
  output logic             tx_valid,
  output logic             tx_last,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             sent
);
  tx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_now;

  assign last_now = (bank_cnt == '0) || (CNT_W'(idx_q) == bank_cnt - 1'b1);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sent    = 1'b0;
    unique case (state_q)
      TX_IDLE: if (start) begin
        state_d = TX_SEND;
        idx_d   = '0;
      end
      TX_SEND: if (last_now) state_d = TX_WAIT;
               else          idx_d   = idx_q + 1'b1;
      TX_WAIT: if (ack) begin
        state_d = TX_IDLE;
        sent    = 1'b1;
      end
      default: state_d = TX_IDLE;
    endcase
    if (ep_clear) begin
      state_d = TX_IDLE;
      idx_d   = '0;
      sent    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign tx_valid = (state_q == TX_SEND) && (bank_cnt != '0);
  assign tx_last  = (state_q == TX_SEND) && last_now;
  assign rd_idx   = idx_q;
  assign busy     = (state_q != TX_IDLE);

  AST_LAST_ENDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> (!tx_valid && !tx_last)); // R2
  AST_SEND_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R3
endmodule

// File: rtl/iso_in_ep_ctrl.sv
module iso_in_ep_ctrl #(
  parameter int DATA_W     = 8,
  parameter int BANK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_enable,
  input  logic              ep_config,
  input  logic              pingpong,
  input  logic              int_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_ready,
  input  logic              clr_done,
  output logic              fw_ready,
  output logic              fw_done,
  output logic              wr_ovf,
  input  logic              in_token,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              tx_ack,
  input  logic              bus_reset_end,
  input  logic              clr_eor,
  output logic              eor_flag,
  output logic              irq
);
  localparam int IDX_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam int CNT_W = $clog2(BANK_DEPTH + 1);

  logic             srst_n;
  logic [1:0]       ready_q, ready_d, done_q, done_d;
  logic             wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic             eor_q, eor_d;
  logic             eor_hit, tok_ok, wr_en, tx_busy, tx_sent;
  logic [CNT_W-1:0] rd_cnt;
  logic [IDX_W-1:0] rd_idx;

  iso_in_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  assign eor_hit = bus_reset_end && !eor_q;
  assign tok_ok  = in_token && ep_enable && ep_config && ready_q[rd_ptr_q] && !tx_busy;
  assign wr_en   = wr_valid && !ready_q[wr_ptr_q] && !done_q[wr_ptr_q];

  iso_in_bank_store #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_store (
    .clk(clk), .rst_n(srst_n), .ep_clear(eor_hit),
    .wr_en(wr_en), .wr_bank(wr_ptr_q), .wr_data(wr_data),
    .rel_en(tx_sent), .rel_bank(rd_ptr_q),
    .rd_bank(rd_ptr_q), .rd_idx(rd_idx),
    .rd_cnt(rd_cnt), .rd_data(tx_data), .ovf(wr_ovf)
  );

  iso_in_tx_seq #(.DEPTH(BANK_DEPTH)) u_seq (
    .clk(clk), .rst_n(srst_n), .ep_clear(eor_hit),
    .start(tok_ok), .bank_cnt(rd_cnt), .ack(tx_ack),
    .tx_valid(tx_valid), .tx_last(tx_last), .rd_idx(rd_idx),
    .busy(tx_busy), .sent(tx_sent)
  );

  always_comb begin
    ready_d  = ready_q;
    done_d   = done_q;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    eor_d    = eor_q;
    if (clr_eor) eor_d = 1'b0;
    if (set_ready && !ready_q[wr_ptr_q]) begin
      ready_d[wr_ptr_q] = 1'b1;
      if (pingpong) wr_ptr_d = ~wr_ptr_q;
    end
    if (clr_done) done_d[wr_ptr_q] = 1'b0;
    if (tx_sent) begin
      ready_d[rd_ptr_q] = 1'b0;
      done_d[rd_ptr_q]  = 1'b1;
      if (pingpong) rd_ptr_d = ~rd_ptr_q;
    end
    if (eor_hit) begin
      ready_d  = '0;
      done_d   = '0;
      wr_ptr_d = 1'b0;
      rd_ptr_d = 1'b0;
      eor_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ready_q  <= '0;
      done_q   <= '0;
      wr_ptr_q <= 1'b0;
      rd_ptr_q <= 1'b0;
      eor_q    <= 1'b0;
    end else begin
      ready_q  <= ready_d;
      done_q   <= done_d;
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      eor_q    <= eor_d;
    end
  end

  assign fw_ready = ready_q[wr_ptr_q];
  assign fw_done  = done_q[wr_ptr_q];
  assign eor_flag = eor_q;
  assign irq      = int_en && ((|done_q) || eor_q);

  AST_TOKEN_GATED: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(tx_busy) |-> $past(ep_enable && ep_config && in_token)); // R1
  AST_SENT_SETS_DONE: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_sent && !eor_hit) |=> done_q[$past(rd_ptr_q)]); // R4
  AST_EOR_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    eor_hit |=> (ready_q == 2'b00 && done_q == 2'b00 && eor_q && !tx_busy)); // R10
  AST_EOR_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    (eor_q && !clr_eor) |=> eor_q); // R11
  AST_SINGLE_PTR: assert property (@(posedge clk) disable iff (!srst_n)
    (!pingpong && !wr_ptr_q) |=> !wr_ptr_q); // R6
endmodule

// File: tb/iso_in_ep_ctrl_tb.sv
module iso_in_ep_ctrl_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int NVEC  = 5;
  localparam int VEC_LEN [NVEC] = '{3, 1, 16, 19, 0};
  localparam int VEC_EXP [NVEC] = '{3, 1, 16, 16, 0};
  localparam int VEC_OVF [NVEC] = '{0, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n, ep_enable, ep_config, pingpong, int_en;
  logic wr_valid, set_ready, clr_done, in_token, tx_ack, bus_reset_end, clr_eor;
  logic [DW-1:0] wr_data, tx_data;
  logic fw_ready, fw_done, wr_ovf, tx_valid, tx_last, eor_flag, irq;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  iso_in_ep_ctrl #(.DATA_W(DW), .BANK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .ep_config(ep_config),
    .pingpong(pingpong), .int_en(int_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .set_ready(set_ready), .clr_done(clr_done), .fw_ready(fw_ready), .fw_done(fw_done),
    .wr_ovf(wr_ovf), .in_token(in_token), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ack(tx_ack), .bus_reset_end(bus_reset_end),
    .clr_eor(clr_eor), .eor_flag(eor_flag), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_data  = DW'(base + i);
      tick();
    end
    wr_valid = 1'b0;
  endtask

  task automatic pulse_ready();
    set_ready = 1'b1; tick(); set_ready = 1'b0;
  endtask

  task automatic pulse_clr_done();
    clr_done = 1'b1; tick(); clr_done = 1'b0;
  endtask

  task automatic pulse_bus_reset();
    bus_reset_end = 1'b1; tick(); bus_reset_end = 1'b0;
  endtask

  task automatic pulse_clr_eor();
    clr_eor = 1'b1; tick(); clr_eor = 1'b0;
  endtask

  task automatic expect_pkt(input int n, input int base, input string req);
    int got = 0;
    bit seen_last = 0;
    bit order_ok = 1;
    in_token = 1'b1; tick(); in_token = 1'b0;
    for (int c = 0; c < DEPTH + 4 && !seen_last; c++) begin
      if (tx_valid) begin
        if (int'(tx_data) != ((base + got) & 8'hFF)) order_ok = 0;
        got++;
      end
      if (tx_last) seen_last = 1;
      else tick();
    end
    chk({req, " byte order"}, int'(order_ok), 1);
    chk({req, " byte count"}, got, n);
    chk({req, " last strobe"}, int'(seen_last), 1);
    tick();
    tx_ack = 1'b1; tick(); tx_ack = 1'b0;
  endtask

  task automatic expect_silent(input string req);
    bit quiet = 1;
    in_token = 1'b1; tick(); in_token = 1'b0;
    for (int c = 0; c < 4; c++) begin
      if (tx_valid || tx_last) quiet = 0;
      tick();
    end
    chk({req, " silent on token"}, int'(quiet), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ep_enable = 1'b0; ep_config = 1'b0; pingpong = 1'b0; int_en = 1'b1;
    wr_valid = 1'b0; wr_data = '0; set_ready = 1'b0; clr_done = 1'b0; in_token = 1'b0;
    tx_ack = 1'b0; bus_reset_end = 1'b0; clr_eor = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    chk("R2 reset tx idle", int'(tx_valid || tx_last), 0);
    chk("R6 reset flags", int'({fw_ready, fw_done}), 0);
    chk("R4 reset irq", int'(irq), 0);
    chk("R10 reset eor/ovf", int'({eor_flag, wr_ovf}), 0);

    // R1: gated by enable and configure
    fill(2, 8'h70);
    pulse_ready();
    expect_silent("R1 disabled");
    chk("R1 bank stays ready", int'(fw_ready), 1);
    ep_config = 1'b1;
    expect_silent("R1 only configured");
    ep_enable = 1'b1;
    expect_pkt(2, 8'h70, "R1 enabled");
    pulse_clr_done();

    // R3: nothing ready
    expect_silent("R3 no ready bank");

    // vector table: single mode, lengths around the bank size
    for (int v = 0; v < NVEC; v++) begin
      int base = 8'h30 + 16 * v;
      fill(VEC_LEN[v], base);
      chk("R8 overflow flag", int'(wr_ovf), VEC_OVF[v]);
      pulse_ready();
      chk("R6 fw_ready single", int'(fw_ready), 1);
      expect_pkt(VEC_EXP[v], base, (VEC_LEN[v] == 0) ? "R9 zero length" : "R2 packet");
      chk("R4 done after ack", int'({fw_ready, fw_done}), 1);
      chk("R4 irq on done", int'(irq), 1);
      pulse_clr_done();
      chk("R4 irq cleared", int'(irq), 0);
      if (VEC_OVF[v] != 0) begin
        pulse_bus_reset();
        chk("R10 eor set", int'(eor_flag), 1);
        chk("R10 ovf cleared", int'(wr_ovf), 0);
        pulse_clr_eor();
        chk("R11 eor cleared", int'(eor_flag), 0);
      end
    end

    // R5: writes blocked while complete flag set
    fill(1, 8'h01);
    pulse_ready();
    expect_pkt(1, 8'h01, "R2 single byte");
    int_en = 1'b0;
    tick();
    chk("R4 irq masked", int'(irq), 0);
    int_en = 1'b1;
    fill(2, 8'hA0);
    pulse_clr_done();
    fill(1, 8'h55);
    pulse_ready();
    expect_pkt(1, 8'h55, "R5 refill after clear");
    pulse_clr_done();

    // R6 / R7: ping-pong
    pingpong = 1'b1;
    fill(3, 8'h10);
    pulse_ready();
    chk("R6 pointer moved to bank1", int'(fw_ready), 0);
    fill(2, 8'h20);
    pulse_ready();
    chk("R6 pointer back on bank0", int'(fw_ready), 1);
    expect_pkt(3, 8'h10, "R7 bank0 first");
    chk("R6 bank0 done seen", int'(fw_done), 1);
    pulse_clr_done();
    expect_pkt(2, 8'h20, "R7 bank1 second");
    chk("R6 view bank0 not done", int'(fw_done), 0);
    chk("R4 irq from bank1", int'(irq), 1);
    expect_silent("R7 next bank not ready");

    // R10 / R11: end of bus reset
    pulse_bus_reset();
    chk("R10 flags cleared", int'({fw_ready, fw_done}), 0);
    chk("R10 eor and irq", int'({eor_flag, irq}), 3);
    pingpong = 1'b0;
    fill(1, 8'h99);
    pulse_ready();
    pulse_bus_reset();
    chk("R11 second pulse ignored", int'(fw_ready), 1);
    chk("R11 flag held", int'(eor_flag), 1);
    pulse_clr_eor();
    chk("R11 flag cleared", int'(eor_flag), 0);
    pulse_bus_reset();
    chk("R10 ready cleared", int'(fw_ready), 0);
    pulse_clr_eor();
    expect_silent("R10 nothing left to send");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule